// File: doc/BRIEF.md
# Synchronous On-Die Termination Sequencer

This block sits on the device side of a double-data-rate memory interface. It takes the sampled termination-request pin and produces a termination-enable output. That output follows the request after a latency of AL + CWL − 2 clock cycles, where AL is the additive latency and CWL is the CAS write latency. The same latency applies to switching termination on and to switching it off. The delay is a shift pipeline with a tap chosen from the two mode settings. The tap is only re-chosen while the termination output is off and the pipeline is empty.

The block also polices the minimum time the request must stay high. Once a rising request is sampled, the request must stay high for four cycles. A write registered while the request is high extends that window: four cycles for a chop-4 burst and six cycles for a full burst of eight. A request sampled low before the window ends sets a sticky violation flag. All sampling is qualified by clock-enable. While clock-enable is low, every pipeline stage, counter and output holds its value.

Top module: `odt_seq`

## Requirements
- R1: A synchronous active-high reset drives `term_en` and `viol` to 0 after the edge that samples it, including in the middle of an active termination, and it empties the latency pipeline.
- R2: With AL=3 and CWL=5, `term_en` rises exactly 6 sampled edges after the first edge where `odt` is sampled high: it is 0 after edges 0..5 and 1 after edge 6, counting that first edge as edge 0.
- R3: `term_en` falls exactly AL+CWL−2 sampled edges after the first edge where `odt` is sampled low. With AL=3 and CWL=5 it is 1 after edges 0..5 and 0 after edge 6.
- R4: The latency follows the programmed values: AL=0 with CWL=5 gives 3, and AL=7 with CWL=10 gives 15. The tap is clamped to the range 1..MAX_LAT.
- R5: An edge with `cke`=0 samples nothing. `odt`, `wr_stb` and `term_en` are ignored or held, and only edges with `cke`=1 count toward the latency.
- R6: Once `odt` is sampled rising, sampling it low at any of the next 3 sampled edges sets `viol`. Sampling it low at the 4th edge or later does not.
- R7: A write (`wr_stb`=1) registered while `odt` is sampled high requires `odt` to stay high for 6 cycles when `wr_bl8`=1 and for 4 cycles when `wr_bl8`=0. Sampling `odt` low at write edge + 5 (full burst) or + 3 (chop) sets `viol`. Sampling it low at + 6 or + 4 respectively does not.
- R8: A write that arrives while a count is running reloads the count with the larger of the remaining count and the new requirement. A chop-4 write one edge after a full-burst write does not shorten the 6-cycle window.
- R9: A write sampled while `odt` is low is ignored. It neither sets `viol` nor lengthens a later high window.
- R10: `viol` stays 1 until reset, whatever legal traffic follows.
- R11: Changing AL or CWL while `term_en` is 1 does not change the pending turn-off latency. The new value takes effect for the next turn-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable; an edge is sampled only when high |
| odt | input | 1 | Termination request pin |
| wr_stb | input | 1 | Write command registered this cycle |
| wr_bl8 | input | 1 | Burst type of the write: 1 = full 8, 0 = chop 4 |
| al | input | AL_W (3) | Additive latency setting |
| cwl | input | CWL_W (4) | CAS write latency setting |
| term_en | output | 1 | Registered termination enable |
| viol | output | 1 | Sticky minimum-high violation flag |

## Verification
`term_en` changes on the sampled edge that is exactly AL+CWL−2 enabled edges after the request edge. `viol` is registered on the very edge that samples the offending low level. The bench therefore drives inputs on the falling clock edge and reads outputs on the next falling edge. It numbers each call as one edge and compares against a value computed from that edge index. Cycles with clock-enable low are counted separately and are excluded from the latency arithmetic. Long idle stretches between scenarios let the pipeline drain, so that each new tap setting is latched before the next request.

// File: rtl/odt_pkg.sv
package odt_pkg;
  // Tap position for a given AL+CWL sum, kept inside the pipeline depth.
  function automatic int clamp_lat(input int sum, input int max_lat);
    if (sum < 3) return 1;
    if (sum - 2 > max_lat) return max_lat;
    return sum - 2;
  endfunction
endpackage

// File: rtl/odt_lat_pipe.sv
module odt_lat_pipe #(
  parameter int AL_W    = 3,
  parameter int CWL_W   = 4,
  parameter int MAX_LAT = 15,
  localparam int LAT_W  = $clog2(MAX_LAT + 1),
  localparam int IDX_W  = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             odt,
  input  logic [AL_W-1:0]  al,
  input  logic [CWL_W-1:0] cwl,
  output logic             term_en
);
  logic [MAX_LAT-1:0] sh;
  logic [LAT_W-1:0]   lat_q;
  logic [LAT_W-1:0]   lat_next;
  logic [IDX_W-1:0]   idx;
  logic               tap;
  logic               idle;
  int                 lat_i;

  always_comb begin
    lat_i    = odt_pkg::clamp_lat(int'(al) + int'(cwl), MAX_LAT);
    lat_next = LAT_W'(lat_i);
    idx      = IDX_W'(lat_q - LAT_W'(1));
    tap      = sh[idx];
    idle     = !term_en && (sh == '0);
  end

  // Tap is re-latched only when no request is in flight and output is off.
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= lat_next;
    end else if (idle) begin
      lat_q <= lat_next;
    end
  end

  generate
    if (MAX_LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sh      <= '0;
          term_en <= 1'b0;
        end else if (cke) begin
          sh      <= odt;
          term_en <= tap;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          sh      <= '0;
          term_en <= 1'b0;
        end else if (cke) begin
          sh      <= {sh[MAX_LAT-2:0], odt};
          term_en <= tap;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/odt_minhigh.sv
module odt_minhigh #(
  parameter int H4    = 4,
  parameter int H8    = 6,
  localparam int CNT_W = $clog2(H8 + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic odt,
  input  logic wr_stb,
  input  logic wr_bl8,
  output logic viol
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_dec;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cnt_nx;
  logic             odt_prev;

  always_comb begin
    cnt_dec = (cnt != '0) ? cnt - CNT_W'(1) : '0;
    base    = (odt && !odt_prev) ? CNT_W'(H4 - 1) : cnt_dec;
    need    = wr_bl8 ? CNT_W'(H8 - 1) : CNT_W'(H4 - 1);
    cnt_nx  = (wr_stb && (need > base)) ? need : base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      odt_prev <= 1'b0;
      viol     <= 1'b0;
    end else if (cke) begin
      odt_prev <= odt;
      if (odt) begin
        cnt <= cnt_nx;
      end else begin
        cnt <= '0;
        if (cnt != '0) viol <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/odt_seq.sv
module odt_seq #(
  parameter int AL_W    = 3,
  parameter int CWL_W   = 4,
  parameter int MAX_LAT = 15,
  parameter int ODTH4   = 4,
  parameter int ODTH8   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             odt,
  input  logic             wr_stb,
  input  logic             wr_bl8,
  input  logic [AL_W-1:0]  al,
  input  logic [CWL_W-1:0] cwl,
  output logic             term_en,
  output logic             viol
);
  odt_lat_pipe #(
    .AL_W(AL_W), .CWL_W(CWL_W), .MAX_LAT(MAX_LAT)
  ) u_pipe (
    .clk(clk), .rst(rst), .cke(cke), .odt(odt),
    .al(al), .cwl(cwl), .term_en(term_en)
  );

  odt_minhigh #(
    .H4(ODTH4), .H8(ODTH8)
  ) u_minhigh (
    .clk(clk), .rst(rst), .cke(cke), .odt(odt),
    .wr_stb(wr_stb), .wr_bl8(wr_bl8), .viol(viol)
  );
endmodule

// File: rtl/odt_seq_chk.sv
module odt_seq_chk (
  input logic clk,
  input logic rst,
  input logic cke,
  input logic odt,
  input logic wr_stb,
  input logic wr_bl8,
  input logic term_en,
  input logic viol
);
  logic       ck_last;
  logic [2:0] ck_run;

  // Independent tracker of high-run length since the last sampled rise.
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_last <= 1'b0;
      ck_run  <= '0;
    end else if (cke) begin
      ck_last <= odt;
      if (!odt)              ck_run <= '0;
      else if (!ck_last)     ck_run <= 3'd1;
      else if (ck_run != 3'd7) ck_run <= ck_run + 3'd1;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!term_en && !viol));

  // R5
  a_r5_hold_term: assert property (@(posedge clk) disable iff (rst)
    !cke |=> $stable(term_en));

  // R5
  a_r5_hold_viol: assert property (@(posedge clk) disable iff (rst)
    !cke |=> $stable(viol));

  // R10
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);

  // R6
  a_r6_early_low: assert property (@(posedge clk) disable iff (rst)
    (cke && !odt && ck_last && (ck_run <= 3'd3)) |=> viol);

  // R9
  a_r9_rise_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(viol) |-> $past(cke && !odt));

  wire unused_ok = &{1'b0, wr_stb, wr_bl8};
endmodule

bind odt_seq odt_seq_chk u_chk (
  .clk(clk), .rst(rst), .cke(cke), .odt(odt), .wr_stb(wr_stb),
  .wr_bl8(wr_bl8), .term_en(term_en), .viol(viol)
);

// File: tb/odt_seq_tb.sv
`timescale 1ns/1ps
module odt_seq_tb;
  logic       clk = 1'b0;
  logic       rst, cke, odt, wr_stb, wr_bl8;
  logic [2:0] al;
  logic [3:0] cwl;
  logic       term_en, viol;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  odt_seq u_dut (
    .clk(clk), .rst(rst), .cke(cke), .odt(odt), .wr_stb(wr_stb),
    .wr_bl8(wr_bl8), .al(al), .cwl(cwl), .term_en(term_en), .viol(viol)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One call = one clock edge; inputs set at negedge, results read at next negedge.
  task automatic tick(input logic c, input logic o, input logic w, input logic b);
    cke = c; odt = o; wr_stb = w; wr_bl8 = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(1, 0, 0, 0);
    tick(1, 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 term_en after reset", term_en, 1'b0);
    chk("R1 viol after reset", viol, 1'b0);
    idle(2);
    for (int i = 0; i < 10; i++) tick(1, 1, 0, 0);
    chk("R1 term on before reset", term_en, 1'b1);
    rst = 1'b1;
    tick(1, 1, 0, 0);
    rst = 1'b0;
    chk("R1 term_en cleared mid-termination", term_en, 1'b0);
    idle(20);
    chk("R1 pipeline emptied", term_en, 1'b0);
  endtask

  task automatic t_on_off(input int a, input int c, input string tag);
    int lat;
    lat = a + c - 2;
    al = 3'(a); cwl = 4'(c);
    idle(20);
    for (int k = 0; k <= lat; k++) begin
      tick(1, 1, 0, 0);
      if (k >= lat - 1) chk({tag, " turn-on edge"}, term_en, (k >= lat));
    end
    for (int k = 0; k < 6; k++) tick(1, 1, 0, 0);
    for (int k = 0; k <= lat; k++) begin
      tick(1, 0, 0, 0);
      if (k >= lat - 1) chk({tag, " turn-off edge"}, term_en, (k < lat));
    end
    idle(20);
  endtask

  task automatic t_cke();
    int n;
    n = 0;
    al = 3'd3; cwl = 4'd5;
    do_reset();
    idle(20);
    for (int i = 0; i < 14; i++) begin
      if ((i % 3) == 1) begin
        tick(0, 0, 1, 1);
        chk("R5 term held while cke low", term_en, (n >= 7));
      end else begin
        tick(1, 1, 0, 0);
        n++;
        if (n >= 6) chk("R5 latency in enabled edges", term_en, (n >= 7));
      end
    end
    chk("R5 no viol from cke-low low odt", viol, 1'b0);
    idle(25);
    chk("R5 term off after drain", term_en, 1'b0);
  endtask

  task automatic t_h4();
    do_reset();
    tick(1, 1, 0, 0);
    tick(1, 1, 0, 0);
    chk("R6 no viol while high", viol, 1'b0);
    tick(1, 0, 0, 0);
    chk("R6 low at rise+2 flags", viol, 1'b1);
    do_reset();
    for (int i = 0; i < 3; i++) tick(1, 1, 0, 0);
    tick(1, 0, 0, 0);
    chk("R6 low at rise+3 flags", viol, 1'b1);
    do_reset();
    for (int i = 0; i < 4; i++) tick(1, 1, 0, 0);
    tick(1, 0, 0, 0);
    chk("R6 low at rise+4 legal", viol, 1'b0);
  endtask

  task automatic wr_case(input logic bl8, input int hi_after, input logic exp,
                         input string tag);
    do_reset();
    for (int i = 0; i < 6; i++) tick(1, 1, 0, 0);
    tick(1, 1, 1, bl8);
    for (int i = 0; i < hi_after; i++) tick(1, 1, 0, 0);
    tick(1, 0, 0, 0);
    chk(tag, viol, exp);
  endtask

  task automatic t_wr();
    wr_case(1'b1, 4, 1'b1, "R7 bl8 low at +5 flags");
    wr_case(1'b1, 5, 1'b0, "R7 bl8 low at +6 legal");
    wr_case(1'b0, 2, 1'b1, "R7 bc4 low at +3 flags");
    wr_case(1'b0, 3, 1'b0, "R7 bc4 low at +4 legal");
  endtask

  task automatic t_reload();
    do_reset();
    for (int i = 0; i < 6; i++) tick(1, 1, 0, 0);
    tick(1, 1, 1, 1);
    tick(1, 1, 1, 0);
    for (int i = 0; i < 3; i++) tick(1, 1, 0, 0);
    tick(1, 0, 0, 0);
    chk("R8 bc4 does not shorten bl8 window", viol, 1'b1);
    do_reset();
    for (int i = 0; i < 6; i++) tick(1, 1, 0, 0);
    tick(1, 1, 1, 1);
    tick(1, 1, 1, 0);
    for (int i = 0; i < 4; i++) tick(1, 1, 0, 0);
    tick(1, 0, 0, 0);
    chk("R8 low at bl8 +6 legal after reload", viol, 1'b0);
  endtask

  task automatic t_ignore();
    do_reset();
    al = 3'd3; cwl = 4'd5;
    idle(20);
    tick(1, 0, 1, 1);
    chk("R9 write with odt low no viol", viol, 1'b0);
    idle(8);
    chk("R9 write with odt low no term", term_en, 1'b0);
    for (int i = 0; i < 4; i++) tick(1, 1, 0, 0);
    tick(1, 0, 0, 0);
    chk("R9 earlier write did not extend window", viol, 1'b0);
    idle(20);
  endtask

  task automatic t_sticky();
    do_reset();
    tick(1, 1, 0, 0);
    tick(1, 0, 0, 0);
    chk("R10 viol set", viol, 1'b1);
    for (int i = 0; i < 10; i++) tick(1, 1, 0, 0);
    idle(20);
    chk("R10 viol still set", viol, 1'b1);
    do_reset();
    chk("R10 viol cleared by reset", viol, 1'b0);
  endtask

  task automatic t_tap();
    do_reset();
    al = 3'd3; cwl = 4'd5;
    idle(20);
    for (int i = 0; i < 10; i++) tick(1, 1, 0, 0);
    chk("R11 term on", term_en, 1'b1);
    al = 3'd0;
    for (int k = 0; k <= 6; k++) begin
      tick(1, 0, 0, 0);
      if (k >= 2) chk("R11 turn-off keeps old latency", term_en, (k < 6));
    end
    idle(20);
    for (int k = 0; k <= 3; k++) begin
      tick(1, 1, 0, 0);
      if (k >= 2) chk("R11 new latency on next turn-on", term_en, (k >= 3));
    end
    idle(25);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst = 1'b1; cke = 1'b1; odt = 1'b0; wr_stb = 1'b0; wr_bl8 = 1'b0;
    al = 3'd3; cwl = 4'd5;
    @(negedge clk);
    t_reset();
    t_on_off(3, 5, "R2 R3 al3 cwl5");
    t_on_off(0, 5, "R4 al0 cwl5");
    t_on_off(7, 10, "R4 al7 cwl10");
    t_cke();
    t_h4();
    t_wr();
    t_reload();
    t_ignore();
    t_sticky();
    t_tap();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end
endmodule